// File: doc/BRIEF.md
# Continuous-Phase Four-Tone FSK Phase Generator

This block produces the phase sequence for a four-tone frequency shift keying transmitter whose data comes from an internal pseudo-noise source. A 15-bit linear feedback shift register supplies two bits per symbol. The two bits form a symbol value, and that value selects one of four per-sample phase steps. For 32 samples the block advances a modulo-64 phase index by the selected step. It folds the index into a signed range and scales it by 1024, which gives a 17-bit signed word for a separate sine stage. The phase index carries across symbol boundaries, so the tone changes with no phase jump.

Samples leave on a streaming interface with valid/ready flow control. A marker flags the first sample of each symbol, and the symbol value is sent alongside the samples. When the consumer holds ready low, everything stands still: the output word, the sample position, the phase and the shift register.

Top module: `fsk4_phase_mod`

## Requirements
- R1: While `rst` is high at a clock edge, the block reloads its state. Afterwards `out_valid` is 0, `out_first` is 1, `out_phase` is 0 and `out_symbol` is 0, the symbol that the seed value 1 gives.
- R2: The shift register is 15 bits wide and is loaded with 1 at reset. Each step forms a new bit from register bit 14 XOR bit 13 (bit 0 is the least significant). The step shifts the register left by one, puts the new bit in bit 0 and delivers that bit as data.
- R3: Each symbol uses two consecutive register steps. The first bit drawn is bit 1 of `out_symbol` and the second is bit 0. `out_symbol` holds the same value for all 32 samples of the symbol.
- R4: Within a symbol, the phase index of each sample is the index of the previous sample plus a step, modulo 64. The step is 9 for symbol 0, 13 for symbol 1, 21 for symbol 2 and 17 for symbol 3. The first symbol after reset starts at index 0.
- R5: The first sample of a symbol has an index equal to the last index of the previous symbol plus that symbol's step, modulo 64.
- R6: `out_phase` is a 17-bit two's-complement word. It equals the index times 1024 when the index is 32 or below, and the index minus 64, times 1024, when the index is above 32. Index 32 gives +32768 and is never wrapped or saturated.
- R7: `out_first` is 1 exactly on sample 0 of every symbol. A symbol is 32 accepted samples long.
- R8: In a cycle with `out_valid` high and `out_ready` low, the next cycle shows the same `out_phase`, `out_first` and `out_symbol`, and the internal sequence does not advance.
- R9: `out_valid` is high on every clock edge at which `rst` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| out_ready | input | 1 | Consumer accepts the current sample |
| out_valid | output | 1 | Current sample is valid |
| out_phase | output | 17 | Signed phase word, ±32768 spans ±π |
| out_first | output | 1 | Current sample is sample 0 of a symbol |
| out_symbol | output | 2 | Symbol value for the current sample |

## Verification
The hardest case to reach is a symbol boundary that meets a stall. The last sample of a symbol is held for several cycles, then accepted, and the new symbol must start from the carried phase with a fresh pair of register bits. The bench drives ready from a pseudo-random pattern that is low about a quarter of the time, with occasional long holds. This lets stalls land on every sample position across more than 500 symbols. A reset in the middle of the run checks that the block reloads its seed from a state it is already streaming in.

// File: rtl/fsk4_pkg.sv
package fsk4_pkg;

    // pseudo-noise source
    localparam int PN_W      = 15;
    localparam int PN_TAP_HI = 14;
    localparam int PN_TAP_LO = 13;
    localparam logic [PN_W-1:0] PN_SEED = PN_W'(1);

    // symbol geometry
    localparam int SYM_BITS  = 2;
    localparam int NUM_TONES = 1 << SYM_BITS;
    localparam int SYM_LEN   = 32;
    localparam int CNT_W     = $clog2(SYM_LEN);

    // phase arithmetic
    localparam int PH_BITS   = 6;                      // 64 units per cycle
    localparam int PH_HALF   = 1 << (PH_BITS - 1);     // 32
    localparam int SCALE_SH  = 10;                     // x1024
    localparam int OUT_W     = PH_BITS + 1 + SCALE_SH; // 17

    typedef logic [SYM_BITS-1:0] sym_t;
    typedef logic [PH_BITS-1:0]  ph_idx_t;
    typedef logic [CNT_W-1:0]    cnt_t;
    typedef logic [PN_W-1:0]     pn_t;

    typedef struct packed {
        logic                    first;
        sym_t                    sym;
        logic signed [OUT_W-1:0] word;
    } sample_t;

    // per-sample step of each tone, indexed by symbol value
    localparam ph_idx_t TONE_STEP [NUM_TONES] = '{
        ph_idx_t'(9), ph_idx_t'(13), ph_idx_t'(21), ph_idx_t'(17)
    };

    function automatic logic pn_feedback(input pn_t s);
        return s[PN_TAP_HI] ^ s[PN_TAP_LO];
    endfunction

    function automatic pn_t pn_advance(input pn_t s);
        return {s[PN_W-2:0], pn_feedback(s)};
    endfunction

    function automatic ph_idx_t tone_step(input sym_t s);
        return TONE_STEP[s];
    endfunction

    // fold index into signed range (32 stays positive) and scale
    function automatic logic signed [OUT_W-1:0] idx_to_word(input ph_idx_t idx);
        logic [PH_BITS:0] t;
        t = {1'b0, idx};
        if (idx > ph_idx_t'(PH_HALF))
            t = t - (PH_BITS+1)'(1 << PH_BITS);
        return signed'({t, {SCALE_SH{1'b0}}});
    endfunction

endpackage

// File: rtl/fsk4_pn_source.sv
module fsk4_pn_source
    import fsk4_pkg::*;
#(
    parameter int DRAWS = SYM_BITS
)(
    input  logic             clk,
    input  logic             rst,
    input  logic             advance,
    output logic [DRAWS-1:0] sym_bits
);
    pn_t state_q;
    pn_t chain [DRAWS+1];

    assign chain[0] = state_q;

    // look-ahead chain: stage k holds the register after k steps
    for (genvar k = 0; k < DRAWS; k++) begin : g_draw
        assign chain[k+1] = pn_advance(chain[k]);
        // first draw lands in the most significant position
        assign sym_bits[DRAWS-1-k] = pn_feedback(chain[k]);
    end

    always_ff @(posedge clk) begin
        if (rst)
            state_q <= PN_SEED;
        else if (advance)
            state_q <= chain[DRAWS];
    end

endmodule

// File: rtl/fsk4_symbol_timer.sv
module fsk4_symbol_timer
    import fsk4_pkg::*;
#(
    parameter int LEN = SYM_LEN
)(
    input  logic clk,
    input  logic rst,
    input  logic accept,
    output logic first,
    output logic last
);
    localparam int W = (LEN > 1) ? $clog2(LEN) : 1;
    localparam logic [W-1:0] LAST_POS = W'(LEN - 1);

    logic [W-1:0] pos_q;

    assign first = (pos_q == '0);
    assign last  = (pos_q == LAST_POS);

    always_ff @(posedge clk) begin
        if (rst)
            pos_q <= '0;
        else if (accept)
            pos_q <= last ? '0 : pos_q + W'(1);
    end

endmodule

// File: rtl/fsk4_phase_acc.sv
module fsk4_phase_acc
    import fsk4_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    accept,
    input  sym_t                    sym,
    output ph_idx_t                 idx,
    output logic signed [OUT_W-1:0] word
);
    ph_idx_t acc_q;

    assign idx  = acc_q;
    assign word = idx_to_word(acc_q);

    // running sum; after the last sample it equals start + 32*step
    always_ff @(posedge clk) begin
        if (rst)
            acc_q <= '0;
        else if (accept)
            acc_q <= acc_q + tone_step(sym);
    end

endmodule

// File: rtl/fsk4_phase_mod.sv
module fsk4_phase_mod
    import fsk4_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    out_ready,
    output logic                    out_valid,
    output logic signed [OUT_W-1:0] out_phase,
    output logic                    out_first,
    output logic [SYM_BITS-1:0]     out_symbol
);
    logic    valid_q;
    logic    accept;
    logic    sym_first;
    logic    sym_last;
    sym_t    cur_sym;
    ph_idx_t cur_idx;
    sample_t smp;

    assign accept = valid_q & out_ready;

    fsk4_pn_source #(.DRAWS(SYM_BITS)) u_pn (
        .clk      (clk),
        .rst      (rst),
        .advance  (accept & sym_last),
        .sym_bits (cur_sym)
    );

    fsk4_symbol_timer #(.LEN(SYM_LEN)) u_timer (
        .clk    (clk),
        .rst    (rst),
        .accept (accept),
        .first  (sym_first),
        .last   (sym_last)
    );

    fsk4_phase_acc u_acc (
        .clk    (clk),
        .rst    (rst),
        .accept (accept),
        .sym    (cur_sym),
        .idx    (cur_idx),
        .word   (smp.word)
    );

    assign smp.first = sym_first;
    assign smp.sym   = cur_sym;

    always_ff @(posedge clk) begin
        if (rst) valid_q <= 1'b0;
        else     valid_q <= 1'b1;
    end

    assign out_valid  = valid_q;
    assign out_phase  = smp.word;
    assign out_first  = smp.first;
    assign out_symbol = smp.sym;

endmodule

// File: rtl/fsk4_phase_mod_checker.sv
module fsk4_phase_mod_checker
    import fsk4_pkg::*;
(
    input logic                    clk,
    input logic                    rst,
    input logic                    out_ready,
    input logic                    out_valid,
    input logic signed [OUT_W-1:0] out_phase,
    input logic                    out_first,
    input logic [SYM_BITS-1:0]     out_symbol
);
    logic accept;
    logic signed [PH_BITS:0] sidx;
    logic [CNT_W-1:0] seen_q;

    assign accept = out_valid & out_ready;
    assign sidx   = out_phase[OUT_W-1:SCALE_SH];

    // independent count of accepted samples within the symbol
    always_ff @(posedge clk) begin
        if (rst)         seen_q <= '0;
        else if (accept) seen_q <= seen_q + CNT_W'(1);
    end

    assert_reset_state_R1: assert property (@(posedge clk)
        rst |=> (!out_valid && out_first && out_phase == '0 && out_symbol == '0));

    assert_step_continuity_R5: assert property (@(posedge clk) disable iff (rst)
        accept |=> (PH_BITS'(sidx - $past(sidx) - signed'({1'b0, tone_step($past(out_symbol))})) == '0));

    assert_symbol_held_R3: assert property (@(posedge clk) disable iff (rst)
        accept |=> (out_first || out_symbol == $past(out_symbol)));

    assert_word_range_R6: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (out_phase[SCALE_SH-1:0] == '0 && sidx != -(PH_BITS+1)'(PH_HALF)));

    assert_first_marker_R7: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (out_first == (seen_q == '0)));

    assert_stall_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> ($stable(out_phase) && $stable(out_first) && $stable(out_symbol)));

    assert_valid_up_R9: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> out_valid);

endmodule

bind fsk4_phase_mod fsk4_phase_mod_checker u_checker (
    .clk        (clk),
    .rst        (rst),
    .out_ready  (out_ready),
    .out_valid  (out_valid),
    .out_phase  (out_phase),
    .out_first  (out_first),
    .out_symbol (out_symbol)
);

// File: tb/fsk4_phase_mod_bench.sv
`timescale 1ns/1ps
module fsk4_phase_mod_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        out_ready = 1'b0;
    logic        out_valid;
    logic [16:0] out_phase;
    logic        out_first;
    logic [1:0]  out_symbol;

    always #2.5 clk = ~clk;

    fsk4_phase_mod u_fsk4_phase_mod (
        .clk        (clk),
        .rst        (rst),
        .out_ready  (out_ready),
        .out_valid  (out_valid),
        .out_phase  (out_phase),
        .out_first  (out_first),
        .out_symbol (out_symbol)
    );

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    // behavioural reference state
    int m_lfsr, m_sym, m_start, m_n;
    int steps [4] = '{9, 13, 21, 17};
    int lcg = 12345;
    int hold_left = 0;
    bit seen_top = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // R2: one register step, returns the fed-back bit
    function automatic int draw_bit();
        int nb;
        nb = ((m_lfsr >> 14) ^ (m_lfsr >> 13)) & 1;
        m_lfsr = ((m_lfsr << 1) | nb) & 32'h7fff;
        return nb;
    endfunction

    function automatic void new_symbol();
        int hi, lo;
        hi = draw_bit();
        lo = draw_bit();
        m_sym = hi * 2 + lo;
    endfunction

    function automatic void model_reset();
        m_lfsr = 1; m_start = 0; m_n = 0;
        new_symbol();
    endfunction

    function automatic int exp_idx();
        return (steps[m_sym] * m_n + m_start) % 64;
    endfunction

    function automatic int to_word(input int idx);
        int s;
        s = (idx > 32) ? idx - 64 : idx;
        return (s * 1024) & 32'h1ffff;
    endfunction

    function automatic int word_idx(input logic [16:0] w);
        return int'(w[16:10]) & 63;
    endfunction

    task automatic do_reset(input int cycles);
        rst = 1'b1;
        out_ready = 1'b1;
        repeat (cycles) begin
            @(negedge clk);
            chk(out_valid == 1'b0, "R1", "valid in reset", out_valid, 0);
            chk(out_first == 1'b1, "R1", "first in reset", out_first, 1);
            chk(out_phase == '0, "R1", "phase in reset", out_phase, 0);
            chk(out_symbol == 2'd0, "R1", "symbol from seed", out_symbol, 0);
        end
        rst = 1'b0;
        model_reset();
    endtask

    task automatic run_symbols(input int nsym);
        int syms = 0;
        int prev_idx = -1;
        int prev_step = 0;
        bit stalled = 0;
        logic [16:0] hold_phase = '0;
        logic        hold_first = 1'b0;
        logic [1:0]  hold_sym = '0;
        while (syms < nsym) begin
            @(negedge clk);
            chk(out_valid == 1'b1, "R9", "valid", out_valid, 1);
            chk(out_first == (m_n == 0), "R7", "first marker", out_first, m_n == 0);
            chk(out_symbol == 2'(m_sym), "R2,R3", "symbol", out_symbol, m_sym);
            chk(out_phase == 17'(to_word(exp_idx())), "R4,R6", "phase word",
                out_phase, to_word(exp_idx()));
            if (exp_idx() == 32) begin
                seen_top = 1;
                chk(out_phase == 17'h08000, "R6", "index 32 word", out_phase, 32768);
            end
            if (m_n == 0 && prev_idx >= 0 && !stalled)
                chk(word_idx(out_phase) == (prev_idx + prev_step) % 64, "R5",
                    "boundary phase", word_idx(out_phase), (prev_idx + prev_step) % 64);
            if (stalled) begin
                chk(out_phase == hold_phase && out_first == hold_first &&
                    out_symbol == hold_sym, "R8", "held outputs", out_phase, hold_phase);
            end
            // choose ready for the coming edge
            lcg = (lcg * 1103515245 + 12345) & 32'h7fffffff;
            if (hold_left > 0) begin
                hold_left--;
                out_ready = 1'b0;
            end else if (((lcg >> 8) % 97) == 0) begin
                hold_left = 6;
                out_ready = 1'b0;
            end else begin
                out_ready = ((lcg >> 12) & 3) != 0;
            end
            stalled    = !out_ready;
            hold_phase = out_phase;
            hold_first = out_first;
            hold_sym   = out_symbol;
            if (out_ready) begin
                if (m_n == 31) begin
                    prev_idx  = exp_idx();
                    prev_step = steps[m_sym];
                    m_start   = (steps[m_sym] * 32 + m_start) % 64;
                    m_n       = 0;
                    new_symbol();
                    syms++;
                end else begin
                    m_n++;
                end
            end
        end
    endtask

    initial begin
        do_reset(3);
        run_symbols(320);
        do_reset(2);   // reload while streaming
        run_symbols(260);
        chk(seen_top == 1, "R6", "index 32 reached", seen_top, 1);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule